// File: doc/BRIEF.md
# Barrel Slot Scheduler

This block lets many virtual processors share one physical micro-engine by handing out the datapath in fixed clock slices. A wheel of 33 slices turns one position per clock. Each slice belongs to one owner, and in that slice the block presents the owner's identity and its saved micro-instruction address. The executing micro-instruction then returns the next address, and the block stores it in that owner's private register. Each owner therefore resumes where it left off on its next turn, even though the datapath changed hands in between.

Shares are unequal. The 24 port controllers get one slice each per turn of the wheel. The executive gets eight slices, placed after every third port slice so that its turns are evenly spaced. The last slice is kept for self-test and issues nothing. A per-owner enable mask lets a slice pass idle. An idle slice leaves its owner's saved address as it was.

A small state machine follows the kind of the current slice. It has three states. `SL_PORT` is a port-controller slice. `SL_EXEC` is an executive slice. `SL_TEST` is the self-test slice. The transitions are:
- `SL_PORT` stays in `SL_PORT` until the third port slice of a group, then moves to `SL_EXEC`.
- `SL_EXEC` returns to `SL_PORT`, except after the eighth executive slice, when it moves to `SL_TEST`.
- `SL_TEST` always moves to `SL_PORT` and starts a new turn of the wheel at position 0.

Top module: `barrel_slot_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, the position is 0 and the owner is 0. Every saved address holds its entry value: 0x040 for the port controllers and 0x400 for the executive. The first visit to each owner after reset shows its entry value.
- R2: The position advances by one each clock from 0 to 32 and then wraps to 0, so one turn of the wheel lasts 33 clocks.
- R3: At a position p below 32 with p mod 4 in {0,1,2}, the owner ID is 3*(p div 4) + (p mod 4). This gives each of the port controllers 0..23 exactly one slice per turn.
- R4: At a position p below 32 with p mod 4 equal to 3, the owner ID is 24, the executive. This gives the executive eight slices per turn.
- R5: At position 32 the self-test flag is 1, the owner ID reads 25, the micro-address reads 0 and no issue is made. At every other position the self-test flag is 0.
- R6: In a port or executive slice, the issue-valid output equals the owner's bit in the enable mask (bit i for port i, bit 24 for the executive).
- R7: In every non-test slice, the micro-address output shows the owner's saved address, whether or not the owner is enabled. When a slice issues and writeback-valid is high in that same cycle, the writeback address replaces that owner's saved address from the next clock.
- R8: A writeback in a slice whose owner is disabled, or in the self-test slice, leaves every saved address unchanged.
- R9: A slice that issues while writeback-valid is low leaves the owner's saved address unchanged.
- R10: A writeback changes only the saved address of the owner of the issuing slice. All other owners keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vp_enable | input | 25 | Enable per owner: bit i for port i, bit 24 for the executive |
| wb_valid | input | 1 | A next address is being returned this cycle |
| wb_addr | input | 11 | Next micro-instruction address for the current owner |
| slot_pos | output | 6 | Current wheel position, 0..32 |
| owner_id | output | 5 | Current owner: 0..23 port, 24 executive, 25 self-test |
| owner_uaddr | output | 11 | Saved micro-address of the current owner |
| issue_valid | output | 1 | A micro-instruction is issued in this slice |
| selftest_slot | output | 1 | The current slice is the self-test slice |

## Verification
The assertions check the wheel's cadence on every cycle: the step-and-wrap of the position, that the executive appears at every fourth position, that the self-test slice sits at the end and stays idle, and that an issue only occurs for an enabled owner. Only the bench scenarios can show that the address registers keep their contents across turns. These scenarios cover a disabled owner, a missing writeback, a writeback aimed at one owner among many, and a reset in the middle of a run. The bench compares every slice of several full turns against an arithmetic model of the wheel and a per-owner address table.

// File: rtl/bps_pkg.sv
package bps_pkg;
    typedef enum logic [1:0] {
        SL_PORT = 2'd0,
        SL_EXEC = 2'd1,
        SL_TEST = 2'd2
    } slice_kind_e;
endpackage

// File: rtl/bps_wheel.sv
module bps_wheel
    import bps_pkg::*;
#(
    parameter int NUM_PORTS   = 24,
    parameter int EXEC_SLICES = 8,
    localparam int PER_GRP    = NUM_PORTS / EXEC_SLICES,
    localparam int NSLICE     = NUM_PORTS + EXEC_SLICES + 1,
    localparam int POS_W      = $clog2(NSLICE),
    localparam int NVP        = NUM_PORTS + 1,
    localparam int ID_W       = $clog2(NVP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [POS_W-1:0]  pos,
    output slice_kind_e       kind,
    output logic [ID_W-1:0]   owner
);
    localparam int K_W  = $clog2(PER_GRP + 1);
    localparam int G_W  = $clog2(EXEC_SLICES + 1);
    localparam int PI_W = $clog2(NUM_PORTS + 1);

    slice_kind_e      state, nstate;
    logic [K_W-1:0]   k_cnt;
    logic [G_W-1:0]   g_cnt;
    logic [PI_W-1:0]  pidx;

    // next-state selection
    always_comb begin
        nstate = state;
        unique case (state)
            SL_PORT: nstate = (k_cnt == K_W'(PER_GRP - 1)) ? SL_EXEC : SL_PORT;
            SL_EXEC: nstate = (g_cnt == G_W'(EXEC_SLICES - 1)) ? SL_TEST : SL_PORT;
            SL_TEST: nstate = SL_PORT;
            default: nstate = SL_PORT;
        endcase
    end

    // state register and slice counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SL_PORT;
            pos   <= '0;
            k_cnt <= '0;
            g_cnt <= '0;
            pidx  <= '0;
        end else begin
            state <= nstate;
            unique case (state)
                SL_PORT: begin
                    pos   <= pos + POS_W'(1);
                    pidx  <= pidx + PI_W'(1);
                    k_cnt <= (k_cnt == K_W'(PER_GRP - 1)) ? '0 : k_cnt + K_W'(1);
                end
                SL_EXEC: begin
                    pos   <= pos + POS_W'(1);
                    g_cnt <= g_cnt + G_W'(1);
                end
                SL_TEST: begin
                    pos   <= '0;
                    pidx  <= '0;
                    k_cnt <= '0;
                    g_cnt <= '0;
                end
                default: begin
                    pos   <= '0;
                end
            endcase
        end
    end

    // outputs from state
    always_comb begin
        kind  = state;
        owner = '0;
        unique case (state)
            SL_PORT: owner = ID_W'(pidx);
            SL_EXEC: owner = ID_W'(NUM_PORTS);
            SL_TEST: owner = ID_W'(NVP);
            default: owner = '0;
        endcase
    end
endmodule

// File: rtl/bps_areg_file.sv
module bps_areg_file #(
    parameter int NVP        = 25,
    parameter int ID_W       = 5,
    parameter int UA_W       = 11,
    parameter int PORT_ENTRY = 'h040,
    parameter int EXEC_ENTRY = 'h400
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ID_W-1:0]            wr_id,
    input  logic [UA_W-1:0]            wr_data,
    output logic [NVP-1:0][UA_W-1:0]   regs
);
    for (genvar i = 0; i < NVP; i++) begin : g_reg
        localparam logic [UA_W-1:0] ENTRY =
            (i < NVP - 1) ? UA_W'(PORT_ENTRY) : UA_W'(EXEC_ENTRY);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= ENTRY;
            end else if (wr_en && (wr_id == ID_W'(i))) begin
                regs[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/bps_issue.sv
module bps_issue
    import bps_pkg::*;
#(
    parameter int NVP  = 25,
    parameter int ID_W = 5,
    parameter int UA_W = 11
) (
    input  slice_kind_e                kind,
    input  logic [ID_W-1:0]            owner,
    input  logic [NVP-1:0]             enable,
    input  logic [NVP-1:0][UA_W-1:0]   regs,
    input  logic                       wb_valid,
    input  logic [UA_W-1:0]            wb_addr,
    output logic                       issue_valid,
    output logic [UA_W-1:0]            uaddr,
    output logic                       wr_en,
    output logic [ID_W-1:0]            wr_id,
    output logic [UA_W-1:0]            wr_data
);
    logic in_range;

    always_comb begin
        in_range    = (owner < ID_W'(NVP));
        issue_valid = 1'b0;
        uaddr       = '0;
        unique case (kind)
            SL_PORT, SL_EXEC: begin
                if (in_range) begin
                    issue_valid = enable[owner];
                    uaddr       = regs[owner];
                end
            end
            SL_TEST: begin
                issue_valid = 1'b0;
                uaddr       = '0;
            end
            default: begin
                issue_valid = 1'b0;
            end
        endcase
        wr_en   = issue_valid && wb_valid;
        wr_id   = owner;
        wr_data = wb_addr;
    end
endmodule

// File: rtl/barrel_slot_sched.sv
module barrel_slot_sched
    import bps_pkg::*;
#(
    parameter int NUM_PORTS   = 24,
    parameter int EXEC_SLICES = 8,
    parameter int UA_W        = 11,
    parameter int PORT_ENTRY  = 'h040,
    parameter int EXEC_ENTRY  = 'h400,
    localparam int NVP        = NUM_PORTS + 1,
    localparam int NSLICE     = NUM_PORTS + EXEC_SLICES + 1,
    localparam int POS_W      = $clog2(NSLICE),
    localparam int ID_W       = $clog2(NVP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NVP-1:0]    vp_enable,
    input  logic              wb_valid,
    input  logic [UA_W-1:0]   wb_addr,
    output logic [POS_W-1:0]  slot_pos,
    output logic [ID_W-1:0]   owner_id,
    output logic [UA_W-1:0]   owner_uaddr,
    output logic              issue_valid,
    output logic              selftest_slot
);
    slice_kind_e               kind;
    logic [NVP-1:0][UA_W-1:0]  regs;
    logic                      wr_en;
    logic [ID_W-1:0]           wr_id;
    logic [UA_W-1:0]           wr_data;

    bps_wheel #(
        .NUM_PORTS   (NUM_PORTS),
        .EXEC_SLICES (EXEC_SLICES)
    ) u_wheel (
        .clk   (clk),
        .rst_n (rst_n),
        .pos   (slot_pos),
        .kind  (kind),
        .owner (owner_id)
    );

    bps_areg_file #(
        .NVP        (NVP),
        .ID_W       (ID_W),
        .UA_W       (UA_W),
        .PORT_ENTRY (PORT_ENTRY),
        .EXEC_ENTRY (EXEC_ENTRY)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_id   (wr_id),
        .wr_data (wr_data),
        .regs    (regs)
    );

    bps_issue #(
        .NVP  (NVP),
        .ID_W (ID_W),
        .UA_W (UA_W)
    ) u_issue (
        .kind        (kind),
        .owner       (owner_id),
        .enable      (vp_enable),
        .regs        (regs),
        .wb_valid    (wb_valid),
        .wb_addr     (wb_addr),
        .issue_valid (issue_valid),
        .uaddr       (owner_uaddr),
        .wr_en       (wr_en),
        .wr_id       (wr_id),
        .wr_data     (wr_data)
    );

    assign selftest_slot = (kind == SL_TEST);
endmodule

// File: rtl/bps_checker.sv
module bps_checker #(
    parameter int NUM_PORTS   = 24,
    parameter int EXEC_SLICES = 8,
    parameter int UA_W        = 11,
    localparam int NVP        = NUM_PORTS + 1,
    localparam int NSLICE     = NUM_PORTS + EXEC_SLICES + 1,
    localparam int POS_W      = $clog2(NSLICE),
    localparam int ID_W       = $clog2(NVP + 1),
    localparam int GRP        = NUM_PORTS / EXEC_SLICES + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NVP-1:0]    vp_enable,
    input logic [POS_W-1:0]  slot_pos,
    input logic [ID_W-1:0]   owner_id,
    input logic              issue_valid,
    input logic              selftest_slot
);
    AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pos == POS_W'(NSLICE - 1)) |=> (slot_pos == '0)); // R2

    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pos != POS_W'(NSLICE - 1)) |=> (slot_pos == $past(slot_pos) + POS_W'(1))); // R2

    AST_EXEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(slot_pos) % GRP == GRP - 1) && (slot_pos != POS_W'(NSLICE - 1)))
        |-> (owner_id == ID_W'(NUM_PORTS))); // R4

    AST_TEST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        selftest_slot |-> (slot_pos == POS_W'(NSLICE - 1)) && !issue_valid); // R5

    AST_ISSUE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (owner_id < ID_W'(NVP)) && vp_enable[owner_id]); // R6
endmodule

bind barrel_slot_sched bps_checker #(
    .NUM_PORTS   (NUM_PORTS),
    .EXEC_SLICES (EXEC_SLICES),
    .UA_W        (UA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vp_enable     (vp_enable),
    .slot_pos      (slot_pos),
    .owner_id      (owner_id),
    .issue_valid   (issue_valid),
    .selftest_slot (selftest_slot)
);

// File: tb/sim_barrel_slot_sched.sv
module sim_barrel_slot_sched;
    localparam int NVP   = 25;
    localparam int NSL   = 33;
    localparam int UA_W  = 11;
    localparam int PENT  = 'h040;
    localparam int EENT  = 'h400;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NVP-1:0]    vp_enable = '1;
    logic              wb_valid = 1'b0;
    logic [UA_W-1:0]   wb_addr = '0;
    logic [5:0]        slot_pos;
    logic [4:0]        owner_id;
    logic [UA_W-1:0]   owner_uaddr;
    logic              issue_valid;
    logic              selftest_slot;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int exp_pos;
    int exp_reg [NVP];

    always #4 clk = ~clk;

    barrel_slot_sched u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .vp_enable     (vp_enable),
        .wb_valid      (wb_valid),
        .wb_addr       (wb_addr),
        .slot_pos      (slot_pos),
        .owner_id      (owner_id),
        .owner_uaddr   (owner_uaddr),
        .issue_valid   (issue_valid),
        .selftest_slot (selftest_slot)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int owner_of(input int p);
        if (p == NSL - 1) return NVP;
        if (p % 4 == 3) return NVP - 1;
        return (p / 4) * 3 + (p % 4);
    endfunction

    // modelled microcode store: next address of a micro-instruction
    function automatic int next_of(input int ua, input int own);
        return (ua * 7 + own + 3) % (1 << UA_W);
    endfunction

    task automatic model_reset();
        exp_pos = 0;
        for (int i = 0; i < NVP; i++) exp_reg[i] = (i < NVP - 1) ? PENT : EENT;
    endtask

    // mode 0: all on, wb always (R7)   mode 1: odd ports and exec off (R8)
    // mode 2: wb on alternate slices (R9)  mode 3: wb only for owner 5 (R10)
    // mode 4: no writeback, entry values after reset (R1)
    task automatic run(input int mode, input int ncyc, input string tag);
        for (int c = 0; c < ncyc; c++) begin
            int own;
            bit ev;
            bit wv;
            int eu;
            for (int i = 0; i < NVP; i++)
                vp_enable[i] = (mode == 1) ? ((i < NVP - 1) && (i % 2 == 0)) : 1'b1;
            own = owner_of(exp_pos);
            ev  = (own < NVP) ? vp_enable[own] : 1'b0;
            eu  = (own < NVP) ? exp_reg[own] : 0;
            chk("R2 pos", int'(slot_pos), exp_pos);
            if (own == NVP)          chk("R5 owner", int'(owner_id), own);
            else if (own == NVP - 1) chk("R4 owner", int'(owner_id), own);
            else                     chk("R3 owner", int'(owner_id), own);
            chk("R5 selftest", int'(selftest_slot), (own == NVP) ? 1 : 0);
            chk("R6 valid", int'(issue_valid), int'(ev));
            chk(tag, int'(owner_uaddr), eu);
            case (mode)
                0, 1:    wv = 1'b1;
                2:       wv = (c % 2 == 0);
                3:       wv = (own == 5);
                default: wv = 1'b0;
            endcase
            wb_valid = wv;
            wb_addr  = UA_W'(next_of(eu, own));
            if (ev && wv) exp_reg[own] = next_of(eu, own);
            exp_pos = (exp_pos == NSL - 1) ? 0 : exp_pos + 1;
            @(negedge clk);
        end
        wb_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset pos", int'(slot_pos), 0);
        chk("R1 reset owner", int'(owner_id), 0);
        chk("R1 reset uaddr", int'(owner_uaddr), PENT);
        rst_n = 1'b1;
        run(4, NSL, "R1 entry");
        model_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run(0, 3 * NSL, "R7 uaddr");
        run(1, 3 * NSL, "R8 uaddr");
        run(2, 3 * NSL, "R9 uaddr");
        run(3, 3 * NSL, "R10 uaddr");
        // mid-run reset: every owner back to its entry value
        model_reset();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset pos", int'(slot_pos), 0);
        rst_n = 1'b1;
        run(4, NSL, "R1 entry");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule